// File: doc/BRIEF.md
# DMA Shadow Register Block Sequencer

This block is the control sequencer for one DMA channel in shadow-register multi-block mode. Software writes the next block's source address, destination address, block size and control word into a shadow set. The sequencer copies them into the active register set when a block starts, so software can load block N+1 while block N is still moving data. Software hands the shadow set over by writing the control word last with its valid marker set. The hardware clears that marker when it takes the set, and software polls the marker to learn when it may reload.

When the channel is enabled, and again at the end of every block that is not marked final, the sequencer tries to fetch a shadow set. If no valid set is present, it raises an invalid-shadow error and waits for software to strobe a resume request. A write to the shadow set while the marker is still set is discarded and flagged as an error. Status bits are sticky and cleared by writing ones, and each one can be routed to the interrupt line through an enable mask. The data mover is outside this block: it sees a one-cycle block-start pulse and reports the end of the block on a done input.

Top module: `shadow_blk_seq`

## Requirements
- R1: After a synchronous active-low reset, the channel is disabled, no shadow set is valid, all status bits are 0, irq is 0, ch_complete is 0 and blk_start is 0.
- R2: An en_set pulse enables the channel only when mb_type equals 2'b10. With any other mb_type value it is ignored: ch_en stays 0 and no block starts.
- R3: A shadow write with sh_sel=3 (control word) and bit 31 of the data set to 1 makes the shadow set valid (sh_valid=1). sh_sel selects 0=source, 1=destination, 2=size (low SIZE_W bits) and 3=control.
- R4: A fetch that finds a valid shadow set copies all four fields into the active outputs in one step and pulses blk_start for exactly one cycle. In the same step it clears the valid marker, so sh_valid and act_ctl bit 31 both read 0.
- R5: A fetch that finds no valid shadow set sets status bit 3 (invalid shadow) and starts no block. The sequencer then waits.
- R6: A resume_wr pulse while waiting makes the sequencer fetch again. A resume_wr pulse at any other time has no effect and is not remembered.
- R7: If bit 30 of the copied control word is 1, the block is final. When blk_done arrives, ch_en clears, ch_complete goes to 1 and status bit 1 (transfer done) is set.
- R8: If bit 30 of the copied control word is 0, the sequencer fetches the shadow set again when blk_done arrives.
- R9: A shadow write while sh_valid is 1 does not change the shadow set and sets status bit 2 (write on valid).
- R10: Once sh_valid reads 0, a new shadow set written while a block is still running is accepted without error and is used at the next block end.
- R11: Status bit 0 (block done) is set at the end of every block.
- R12: Status bits are sticky. Writing sts_clr_wr with a 1 in a bit position clears that bit, and the other bits are kept.
- R13: irq is 1 exactly when some status bit is 1 and its irq_mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mb_type | input | 2 | Multi-block type; 2'b10 selects shadow mode |
| en_set | input | 1 | Channel enable request pulse |
| sh_wr | input | 1 | Shadow register write strobe |
| sh_sel | input | 2 | Shadow register select |
| sh_wdata | input | DATA_W | Shadow write data |
| resume_wr | input | 1 | Resume request write strobe |
| blk_done | input | 1 | End of current block from the data mover |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_data | input | 4 | Status bits to clear (write one to clear) |
| irq_mask | input | 4 | Interrupt enable per status bit |
| ch_en | output | 1 | Channel enabled |
| sh_valid | output | 1 | Shadow valid marker readback |
| act_src | output | ADDR_W | Active source address |
| act_dst | output | ADDR_W | Active destination address |
| act_size | output | SIZE_W | Active block size |
| act_ctl | output | CTL_W | Active control word |
| blk_start | output | 1 | One-cycle block start pulse |
| ch_complete | output | 1 | Final block finished |
| sts | output | 4 | Sticky status: 0 block done, 1 transfer done, 2 write on valid, 3 invalid shadow |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach is a resume that arrives too early. A resume strobe is issued while a non-final block is still running, and the shadow set stays empty. The bench uses a ten-cycle block so the strobe falls inside the running block. It then checks that the channel parks with an invalid-shadow error and starts nothing, then reloads the shadow and resumes it explicitly. A rejected write is produced by rewriting the source register after the control word while the channel is still disabled. The bench later shows that the block started with the original address.

// File: rtl/shseq_pkg.sv
package shseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT_RESUME,
        ST_ACTIVE,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_SIZE = 2'd2;
    localparam logic [1:0] SEL_CTL  = 2'd3;

    localparam logic [1:0] MB_SHADOW = 2'b10;

    localparam int STS_W       = 4;
    localparam int STS_BLK     = 0;
    localparam int STS_XFER    = 1;
    localparam int STS_WOV     = 2;
    localparam int STS_INVALID = 3;

endpackage

// File: rtl/shseq_bank.sv
module shseq_bank
    import shseq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 16,
    parameter int CTL_W     = 32,
    parameter int VALID_POS = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic [ADDR_W-1:0] sh_src,
    output logic [ADDR_W-1:0] sh_dst,
    output logic [SIZE_W-1:0] sh_size,
    output logic [CTL_W-1:0]  sh_ctl,
    output logic              valid,
    output logic              wov_evt
);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [SIZE_W-1:0] size;
        logic [CTL_W-1:0]  ctl;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d  = bank_q;
        wov_evt = 1'b0;
        if (wr) begin
            if (bank_q.ctl[VALID_POS]) begin
                wov_evt = 1'b1;
            end else begin
                case (sel)
                    SEL_SRC:  bank_d.src  = wdata[ADDR_W-1:0];
                    SEL_DST:  bank_d.dst  = wdata[ADDR_W-1:0];
                    SEL_SIZE: bank_d.size = wdata[SIZE_W-1:0];
                    default:  bank_d.ctl  = wdata[CTL_W-1:0];
                endcase
            end
        end
        if (take) begin
            bank_d.ctl[VALID_POS] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign sh_src  = bank_q.src;
    assign sh_dst  = bank_q.dst;
    assign sh_size = bank_q.size;
    assign sh_ctl  = bank_q.ctl;
    assign valid   = bank_q.ctl[VALID_POS];

endmodule

// File: rtl/shseq_fsm.sv
module shseq_fsm
    import shseq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 16,
    parameter int CTL_W     = 32,
    parameter int VALID_POS = 31,
    parameter int FINAL_POS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ok,
    input  logic              en_set,
    input  logic              resume,
    input  logic              blk_done,
    input  logic              sh_valid,
    input  logic [ADDR_W-1:0] sh_src,
    input  logic [ADDR_W-1:0] sh_dst,
    input  logic [SIZE_W-1:0] sh_size,
    input  logic [CTL_W-1:0]  sh_ctl,
    output logic              take,
    output logic [ADDR_W-1:0] act_src,
    output logic [ADDR_W-1:0] act_dst,
    output logic [SIZE_W-1:0] act_size,
    output logic [CTL_W-1:0]  act_ctl,
    output logic              blk_start,
    output logic              ch_en,
    output logic              ch_complete,
    output logic              ev_blk,
    output logic              ev_xfer,
    output logic              ev_invalid
);

    typedef struct packed {
        seq_state_e        state;
        logic              en;
        logic              complete;
        logic              start;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [SIZE_W-1:0] size;
        logic [CTL_W-1:0]  ctl;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        take        = 1'b0;
        ev_blk      = 1'b0;
        ev_xfer     = 1'b0;
        ev_invalid  = 1'b0;

        if (en_set && mode_ok && !seq_q.en && seq_q.state == ST_IDLE) begin
            seq_d.en       = 1'b1;
            seq_d.complete = 1'b0;
        end

        case (seq_q.state)
            ST_IDLE: begin
                if (seq_q.en && mode_ok) begin
                    seq_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (sh_valid) begin
                    take                 = 1'b1;
                    seq_d.src            = sh_src;
                    seq_d.dst            = sh_dst;
                    seq_d.size           = sh_size;
                    seq_d.ctl            = sh_ctl;
                    seq_d.ctl[VALID_POS] = 1'b0;
                    seq_d.start          = 1'b1;
                    seq_d.state          = ST_ACTIVE;
                end else begin
                    ev_invalid  = 1'b1;
                    seq_d.state = ST_WAIT_RESUME;
                end
            end
            ST_WAIT_RESUME: begin
                if (resume) begin
                    seq_d.state = ST_FETCH;
                end
            end
            ST_ACTIVE: begin
                if (blk_done) begin
                    ev_blk = 1'b1;
                    if (seq_q.ctl[FINAL_POS]) begin
                        seq_d.state = ST_DONE;
                    end else begin
                        seq_d.state = ST_FETCH;
                    end
                end
            end
            ST_DONE: begin
                ev_xfer        = 1'b1;
                seq_d.en       = 1'b0;
                seq_d.complete = 1'b1;
                seq_d.state    = ST_IDLE;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign act_src     = seq_q.src;
    assign act_dst     = seq_q.dst;
    assign act_size    = seq_q.size;
    assign act_ctl     = seq_q.ctl;
    assign blk_start   = seq_q.start;
    assign ch_en       = seq_q.en;
    assign ch_complete = seq_q.complete;

endmodule

// File: rtl/shseq_irq.sv
module shseq_irq
    import shseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] set_vec,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] clr_data,
    input  logic [STS_W-1:0] mask,
    output logic [STS_W-1:0] sts,
    output logic             irq
);

    logic [STS_W-1:0] sts_d, sts_q;

    always_comb begin
        sts_d = sts_q;
        if (clr_wr) begin
            sts_d = sts_d & ~clr_data;
        end
        sts_d = sts_d | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= sts_d;
        end
    end

    assign sts = sts_q;
    assign irq = |(sts_q & mask);

endmodule

// File: rtl/shadow_blk_seq.sv
module shadow_blk_seq
    import shseq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 16,
    parameter int CTL_W     = 32,
    parameter int VALID_POS = 31,
    parameter int FINAL_POS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mb_type,
    input  logic              en_set,
    input  logic              sh_wr,
    input  logic [1:0]        sh_sel,
    input  logic [DATA_W-1:0] sh_wdata,
    input  logic              resume_wr,
    input  logic              blk_done,
    input  logic              sts_clr_wr,
    input  logic [3:0]        sts_clr_data,
    input  logic [3:0]        irq_mask,
    output logic              ch_en,
    output logic              sh_valid,
    output logic [ADDR_W-1:0] act_src,
    output logic [ADDR_W-1:0] act_dst,
    output logic [SIZE_W-1:0] act_size,
    output logic [CTL_W-1:0]  act_ctl,
    output logic              blk_start,
    output logic              ch_complete,
    output logic [3:0]        sts,
    output logic              irq
);

    logic [ADDR_W-1:0] sh_src, sh_dst;
    logic [SIZE_W-1:0] sh_size;
    logic [CTL_W-1:0]  sh_ctl;
    logic              take, wov_evt;
    logic              ev_blk, ev_xfer, ev_invalid;
    logic [STS_W-1:0]  set_vec;
    logic              mode_ok;

    assign mode_ok = (mb_type == MB_SHADOW);

    shseq_bank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
        .CTL_W(CTL_W), .VALID_POS(VALID_POS)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr(sh_wr), .sel(sh_sel), .wdata(sh_wdata),
        .take(take), .sh_src(sh_src), .sh_dst(sh_dst), .sh_size(sh_size),
        .sh_ctl(sh_ctl), .valid(sh_valid), .wov_evt(wov_evt)
    );

    shseq_fsm #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CTL_W(CTL_W),
        .VALID_POS(VALID_POS), .FINAL_POS(FINAL_POS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_ok(mode_ok), .en_set(en_set),
        .resume(resume_wr), .blk_done(blk_done), .sh_valid(sh_valid),
        .sh_src(sh_src), .sh_dst(sh_dst), .sh_size(sh_size), .sh_ctl(sh_ctl),
        .take(take), .act_src(act_src), .act_dst(act_dst), .act_size(act_size),
        .act_ctl(act_ctl), .blk_start(blk_start), .ch_en(ch_en),
        .ch_complete(ch_complete), .ev_blk(ev_blk), .ev_xfer(ev_xfer),
        .ev_invalid(ev_invalid)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[STS_BLK]     = ev_blk;
        set_vec[STS_XFER]    = ev_xfer;
        set_vec[STS_WOV]     = wov_evt;
        set_vec[STS_INVALID] = ev_invalid;
    end

    shseq_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_wr(sts_clr_wr),
        .clr_data(sts_clr_data), .mask(irq_mask), .sts(sts), .irq(irq)
    );

endmodule

// File: rtl/shseq_chk.sv
module shseq_chk #(
    parameter int ADDR_W    = 32,
    parameter int CTL_W     = 32,
    parameter int VALID_POS = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mb_type,
    input logic              en_set,
    input logic              sh_wr,
    input logic              sh_valid,
    input logic              blk_start,
    input logic [ADDR_W-1:0] act_src,
    input logic [CTL_W-1:0]  act_ctl,
    input logic              ch_en,
    input logic              ch_complete,
    input logic [3:0]        sts
);

    // R4
    blk_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> !blk_start);

    // R4
    copy_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |-> (!sh_valid && !act_ctl[VALID_POS]));

    // R4
    active_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_src) |-> blk_start);

    // R9
    write_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_wr && sh_valid) |=> sts[2]);

    // R7
    done_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_complete) |-> !ch_en);

    // R2
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set && mb_type != 2'b10 && !ch_en) |=> !ch_en);

endmodule

bind shadow_blk_seq shseq_chk #(
    .ADDR_W(ADDR_W), .CTL_W(CTL_W), .VALID_POS(VALID_POS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mb_type(mb_type), .en_set(en_set),
    .sh_wr(sh_wr), .sh_valid(sh_valid), .blk_start(blk_start),
    .act_src(act_src), .act_ctl(act_ctl), .ch_en(ch_en),
    .ch_complete(ch_complete), .sts(sts)
);

// File: tb/sim_shadow_blk_seq.sv
`timescale 1ns/1ps
module sim_shadow_blk_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mb_type = 2'b10;
    logic        en_set = 1'b0;
    logic        sh_wr = 1'b0;
    logic [1:0]  sh_sel = 2'd0;
    logic [31:0] sh_wdata = '0;
    logic        resume_wr = 1'b0;
    logic        blk_done;
    logic        sts_clr_wr = 1'b0;
    logic [3:0]  sts_clr_data = '0;
    logic [3:0]  irq_mask = '0;
    logic        ch_en, sh_valid, blk_start, ch_complete, irq;
    logic [31:0] act_src, act_dst, act_ctl;
    logic [15:0] act_size;
    logic [3:0]  sts;

    int checks = 0;
    int fails  = 0;
    int n_start = 0;
    logic [31:0] last_src = '0;
    logic [15:0] eng_cnt;

    localparam logic [31:0] V = 32'h8000_0000;
    localparam logic [31:0] F = 32'h4000_0000;

    always #2 clk = ~clk;

    shadow_blk_seq u0 (
        .clk(clk), .rst_n(rst_n), .mb_type(mb_type), .en_set(en_set),
        .sh_wr(sh_wr), .sh_sel(sh_sel), .sh_wdata(sh_wdata),
        .resume_wr(resume_wr), .blk_done(blk_done), .sts_clr_wr(sts_clr_wr),
        .sts_clr_data(sts_clr_data), .irq_mask(irq_mask), .ch_en(ch_en),
        .sh_valid(sh_valid), .act_src(act_src), .act_dst(act_dst),
        .act_size(act_size), .act_ctl(act_ctl), .blk_start(blk_start),
        .ch_complete(ch_complete), .sts(sts), .irq(irq)
    );

    // data mover model: block lasts act_size cycles
    always @(posedge clk) begin
        if (!rst_n) eng_cnt <= '0;
        else if (blk_start) eng_cnt <= act_size;
        else if (eng_cnt != 0) eng_cnt <= eng_cnt - 16'd1;
    end
    assign blk_done = (eng_cnt == 16'd1);

    always @(negedge clk) begin
        if (blk_start) begin
            n_start  = n_start + 1;
            last_src = act_src;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_sh(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); sh_wr = 1'b1; sh_sel = sel; sh_wdata = d;
        @(negedge clk); sh_wr = 1'b0;
    endtask

    task automatic load_set(input logic [31:0] s, input logic [31:0] d, input logic [15:0] sz, input logic [31:0] ctl);
        wr_sh(2'd0, s); wr_sh(2'd1, d); wr_sh(2'd2, {16'h0, sz}); wr_sh(2'd3, ctl);
    endtask

    task automatic pulse_en();
        @(negedge clk); en_set = 1'b1;
        @(negedge clk); en_set = 1'b0;
    endtask

    task automatic pulse_resume();
        @(negedge clk); resume_wr = 1'b1;
        @(negedge clk); resume_wr = 1'b0;
    endtask

    task automatic clr_sts(input logic [3:0] m);
        @(negedge clk); sts_clr_wr = 1'b1; sts_clr_data = m;
        @(negedge clk); sts_clr_wr = 1'b0;
    endtask

    task automatic wait_complete();
        for (int i = 0; i < 500 && !ch_complete; i++) @(negedge clk);
    endtask

    task automatic wait_start(input int target);
        for (int i = 0; i < 500 && n_start < target; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!ch_en, "R1 ch_en", {31'b0, ch_en}, 0);
        chk(!sh_valid, "R1 sh_valid", {31'b0, sh_valid}, 0);
        chk(sts == 4'h0, "R1 sts", {28'b0, sts}, 0);
        chk(!irq && !ch_complete && !blk_start, "R1 irq/complete/start",
            {29'b0, irq, ch_complete, blk_start}, 0);
    endtask

    task automatic t_single();
        n_start = 0;
        load_set(32'h1000_0000, 32'h2000_0000, 16'd3, V | F | 32'h5);
        chk(sh_valid, "R3 valid after ctl write", {31'b0, sh_valid}, 1);
        pulse_en();
        chk(ch_en, "R2 enabled in shadow mode", {31'b0, ch_en}, 1);
        wait_complete();
        chk(n_start == 1, "R4 one block start", n_start, 1);
        chk(act_src == 32'h1000_0000 && act_dst == 32'h2000_0000 && act_size == 16'd3,
            "R4 fields copied", act_dst, 32'h2000_0000);
        chk(act_ctl == (F | 32'h5), "R4 active ctl valid cleared", act_ctl, F | 32'h5);
        chk(!sh_valid, "R4 shadow flag cleared", {31'b0, sh_valid}, 0);
        chk(!ch_en && ch_complete, "R7 channel complete", {30'b0, ch_en, ch_complete}, 1);
        chk(sts == 4'b0011, "R11 R7 status bits", {28'b0, sts}, 3);
        clr_sts(4'b0001);
        chk(sts == 4'b0010, "R12 partial clear", {28'b0, sts}, 2);
        clr_sts(4'b0010);
        chk(sts == 4'b0000, "R12 cleared", {28'b0, sts}, 0);
    endtask

    task automatic t_multi();
        n_start = 0;
        load_set(32'hA000_0000, 32'hA100_0000, 16'd20, V);
        pulse_en();
        wait_start(1);
        cyc(2);
        chk(!sh_valid, "R10 flag reads 0 mid-block", {31'b0, sh_valid}, 0);
        load_set(32'hB000_0000, 32'hB100_0000, 16'd4, V | F);
        chk(n_start == 1 && sh_valid, "R10 reload during block", n_start, 1);
        wait_complete();
        chk(n_start == 2, "R8 second block fetched", n_start, 2);
        chk(last_src == 32'hB000_0000, "R10 reloaded set used", last_src, 32'hB000_0000);
        chk(sts == 4'b0011, "R10 no error on reload", {28'b0, sts}, 3);
        clr_sts(4'hF);
    endtask

    task automatic t_wov();
        n_start = 0;
        load_set(32'hC000_0000, 32'hC100_0000, 16'd4, V | F);
        wr_sh(2'd0, 32'hDEAD_0000);
        chk(sts[2], "R9 write-on-valid flagged", {28'b0, sts}, 4);
        irq_mask = 4'b0100; cyc(1);
        chk(irq, "R13 irq unmasked", {31'b0, irq}, 1);
        irq_mask = 4'b1011; cyc(1);
        chk(!irq, "R13 irq masked", {31'b0, irq}, 0);
        irq_mask = 4'b0000;
        pulse_en();
        wait_complete();
        chk(last_src == 32'hC000_0000, "R9 rejected write ignored", last_src, 32'hC000_0000);
        clr_sts(4'hF);
    endtask

    task automatic t_stall();
        n_start = 0;
        pulse_en();
        cyc(5);
        chk(sts[3], "R5 invalid shadow flagged", {28'b0, sts}, 8);
        chk(n_start == 0, "R5 no start while empty", n_start, 0);
        clr_sts(4'b1000);
        pulse_resume();
        cyc(3);
        chk(sts[3] && n_start == 0, "R6 resume refetch still empty", {28'b0, sts}, 8);
        load_set(32'hD000_0000, 32'hD100_0000, 16'd2, V | F);
        cyc(5);
        chk(n_start == 0, "R5 waits for resume", n_start, 0);
        pulse_resume();
        wait_complete();
        chk(n_start == 1 && last_src == 32'hD000_0000, "R6 resume starts block", last_src, 32'hD000_0000);
        clr_sts(4'hF);
    endtask

    task automatic t_early_resume();
        n_start = 0;
        load_set(32'hE000_0000, 32'hE100_0000, 16'd10, V);
        pulse_en();
        wait_start(1);
        pulse_resume();
        for (int i = 0; i < 100 && !sts[3]; i++) @(negedge clk);
        cyc(10);
        chk(sts[3] && n_start == 1, "R6 early resume not remembered", n_start, 1);
        chk(sts[0], "R11 block done set", {28'b0, sts}, 9);
        load_set(32'hE200_0000, 32'hE300_0000, 16'd2, V | F);
        chk(sh_valid, "R3 valid while waiting", {31'b0, sh_valid}, 1);
        pulse_resume();
        wait_complete();
        chk(n_start == 2 && last_src == 32'hE200_0000, "R6 resume after reload", last_src, 32'hE200_0000);
        clr_sts(4'hF);
    endtask

    task automatic t_mode();
        n_start = 0;
        mb_type = 2'b01;
        load_set(32'hF000_0000, 32'hF100_0000, 16'd2, V | F);
        pulse_en();
        cyc(10);
        chk(!ch_en && n_start == 0, "R2 enable ignored in other mode", {31'b0, ch_en}, 0);
        mb_type = 2'b10;
        pulse_en();
        wait_complete();
        chk(n_start == 1 && last_src == 32'hF000_0000, "R2 enable in shadow mode", last_src, 32'hF000_0000);
        clr_sts(4'hF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_single();
        t_multi();
        t_wov();
        t_stall();
        t_early_resume();
        t_mode();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule